// File: doc/BRIEF.md
# Freefall and High-g Interrupt Engine

This block watches three axis samples, each an unsigned 8-bit value centred on 128 for zero g. It reports two kinds of event. Free-fall means every axis is close to zero g at the same time. High-g motion means at least one axis is far from zero g. A qualifying condition has to be seen on a programmable number of consecutive sample strobes before its flag rises. The strobes come from an internal divider, and a 2-bit code selects one of four sample rates.

Each flag can be level-following or sticky, and each sticky flag has its own release. A sticky motion flag clears when the motion-enable pin goes low. A sticky free-fall flag clears when the free-fall enable goes low. The two flags are merged onto one interrupt pin, and the motion flag is gated by the motion-enable pin. Threshold and delay settings sit in a small holding stage. That stage starts at fixed defaults and loads from the input ports on a write pulse.

Top module: `ffmot_irq_engine`

## Requirements
- R1: The free-fall condition holds on a strobe when every axis has magnitude |s-128| strictly below the free-fall threshold. Axis 0 is bits 7:0 of `axes_i`, axis 1 is bits 15:8 and axis 2 is bits 23:16.
- R2: The motion condition holds on a strobe when at least one axis has magnitude |s-128| strictly above the motion threshold.
- R3: With delay D, a flag rises on the (D+1)th consecutive strobe on which its condition holds. D=0 means the first such strobe. A strobe on which the condition fails restarts the count. Flags rise only on strobe edges.
- R4: With `CLK_PER_TICK`=B, strobes come every 64·B clocks for `rate_sel_i`=00, every 16·B for 01, every 4·B for 10 and every B for 11. The first strobe after reset falls on the B-th active clock edge, and the strobe phase is shared by all codes.
- R5: `irq_o` = `ff_flag_o` OR (`mot_flag_o` AND `mot_en_i`).
- R6: A flag whose latch bit is 0 is low after the first strobe on which its condition fails.
- R7: With `mot_latch_i`=1, a raised motion flag stays high until `mot_en_i` is low on a clock edge. While `mot_en_i` is low, that flag and its count are cleared.
- R8: With `ff_latch_i`=1, a raised free-fall flag stays high until `ff_en_i` is low on a clock edge. Whenever `ff_en_i` is 0, the free-fall flag and its count are held at 0 and free-fall never drives `irq_o`.
- R9: After reset the free-fall threshold is 0x0E, the motion threshold is 0x55 and both delays are 1, and both flags and `irq_o` are 0. A clock edge with `cfg_wr_i`=1 loads all four settings from their ports, and they take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| axes_i | input | 24 | Three 8-bit axis samples, axis 0 in the low byte |
| rate_sel_i | input | 2 | Sample rate code |
| cfg_wr_i | input | 1 | Loads the four settings below |
| ff_thr_i | input | 8 | Free-fall threshold to load |
| mot_thr_i | input | 8 | Motion threshold to load |
| ff_dly_i | input | 8 | Free-fall delay in strobes, to load |
| mot_dly_i | input | 8 | Motion delay in strobes, to load |
| ff_latch_i | input | 1 | 1 makes the free-fall flag sticky |
| mot_latch_i | input | 1 | 1 makes the motion flag sticky |
| ff_en_i | input | 1 | Free-fall enable; low clears and holds off free-fall |
| mot_en_i | input | 1 | Motion enable pin; gates the motion flag onto the interrupt |
| irq_o | output | 1 | Combined interrupt |
| ff_flag_o | output | 1 | Free-fall flag |
| mot_flag_o | output | 1 | Motion flag |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. The exclusivity check between the below and above results of an axis assumes only that the free-fall threshold does not exceed the motion threshold. The stimulus changes inputs only on falling edges. It writes settings with a single-cycle pulse, and it sets thresholds so that the below and above conditions both occur across runs.

// File: rtl/ffm_pkg.sv
package ffm_pkg;
  localparam int SAMPLE_W = 8;
  localparam int DLY_W    = 8;
  localparam int RATE_W   = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_250  = 2'b00,
    RATE_1K   = 2'b01,
    RATE_4K   = 2'b10,
    RATE_16K  = 2'b11
  } rate_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] ff_thr;
    logic [SAMPLE_W-1:0] mot_thr;
    logic [DLY_W-1:0]    ff_dly;
    logic [DLY_W-1:0]    mot_dly;
  } cfg_t;

  localparam logic [SAMPLE_W-1:0] FF_THR_RST  = 8'h0E;
  localparam logic [SAMPLE_W-1:0] MOT_THR_RST = 8'h55;
  localparam logic [DLY_W-1:0]    FF_DLY_RST  = 8'h01;
  localparam logic [DLY_W-1:0]    MOT_DLY_RST = 8'h01;
endpackage

// File: rtl/ffm_cfg_hold.sv
module ffm_cfg_hold
  import ffm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SAMPLE_W-1:0] ff_thr,
  input  logic [SAMPLE_W-1:0] mot_thr,
  input  logic [DLY_W-1:0]    ff_dly,
  input  logic [DLY_W-1:0]    mot_dly,
  output cfg_t                cfg
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d.ff_thr  = ff_thr;
      cfg_d.mot_thr = mot_thr;
      cfg_d.ff_dly  = ff_dly;
      cfg_d.mot_dly = mot_dly;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.ff_thr  <= FF_THR_RST;
      cfg_q.mot_thr <= MOT_THR_RST;
      cfg_q.ff_dly  <= FF_DLY_RST;
      cfg_q.mot_dly <= MOT_DLY_RST;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q)) else $error("config changed without write"); // R9
endmodule

// File: rtl/ffm_rate_gen.sv
module ffm_rate_gen
  import ffm_pkg::*;
#(
  parameter int CLK_PER_TICK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              strobe
);
  localparam int PRE_W  = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int MAXC   = (1 << RATE_W) - 1;
  localparam int TICK_W = 2 * MAXC;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_TICK - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [TICK_W-1:0] mask;
  logic              tick;
  logic [RATE_W:0]   shift_amt;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    shift_amt = (RATE_W+1)'(MAXC) - {1'b0, rate_sel};
    mask = TICK_W'(({ {TICK_W{1'b0}}, 1'b1 } << (2 * shift_amt)) - 1'b1);
  end

  always_comb begin
    pre_d  = pre_q;
    tick_d = tick_q;
    if (tick) begin
      pre_d  = '0;
      tick_d = tick_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q  <= pre_d;
      tick_q <= tick_d;
    end
  end

  assign strobe = tick && ((tick_q & mask) == mask);

  AST_STROBE_FAST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && CLK_PER_TICK > 1) |=> !strobe) else $error("back-to-back strobe"); // R4
endmodule

// File: rtl/ffm_axis_cmp.sv
module ffm_axis_cmp
  import ffm_pkg::*;
(
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] ff_thr,
  input  logic [SAMPLE_W-1:0] mot_thr,
  output logic                below,
  output logic                above
);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic [SAMPLE_W-1:0] mag;

  always_comb begin
    if (sample >= MID) mag = sample - MID;
    else               mag = MID - sample;
  end

  assign below = (mag < ff_thr);
  assign above = (mag > mot_thr);
endmodule

// File: rtl/ffm_event_det.sv
module ffm_event_det
  import ffm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             crit,
  input  logic [DLY_W-1:0] dly,
  input  logic             latch,
  input  logic             clr,
  output logic             flag
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             qual;

  assign qual = crit && (cnt_q >= dly);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (strobe) begin
      if (!crit)     cnt_d = '0;
      else if (!qual) cnt_d = cnt_q + 1'b1;
      flag_d = latch ? (flag_q | qual) : qual;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(strobe)) else $error("flag rose off strobe"); // R3
  AST_UNLATCHED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !crit && !latch) |=> !flag_q) else $error("flag kept after fail"); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && latch && !clr) |=> flag_q) else $error("latched flag lost"); // R7
endmodule

// File: rtl/ffmot_irq_engine.sv
module ffmot_irq_engine
  import ffm_pkg::*;
#(
  parameter int NUM_AXES     = 3,
  parameter int CLK_PER_TICK = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_AXES*SAMPLE_W-1:0] axes_i,
  input  logic [RATE_W-1:0]            rate_sel_i,
  input  logic                         cfg_wr_i,
  input  logic [SAMPLE_W-1:0]          ff_thr_i,
  input  logic [SAMPLE_W-1:0]          mot_thr_i,
  input  logic [DLY_W-1:0]             ff_dly_i,
  input  logic [DLY_W-1:0]             mot_dly_i,
  input  logic                         ff_latch_i,
  input  logic                         mot_latch_i,
  input  logic                         ff_en_i,
  input  logic                         mot_en_i,
  output logic                         irq_o,
  output logic                         ff_flag_o,
  output logic                         mot_flag_o
);
  logic sync1_q, sync2_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_int_n = sync2_q;

  cfg_t cfg;
  logic strobe;
  logic [NUM_AXES-1:0] below, above;
  logic ff_crit, mot_crit;
  logic ff_clr, mot_clr;
  logic ff_flag, mot_flag;

  ffm_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr(cfg_wr_i),
    .ff_thr(ff_thr_i), .mot_thr(mot_thr_i),
    .ff_dly(ff_dly_i), .mot_dly(mot_dly_i), .cfg(cfg)
  );

  ffm_rate_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .rate_sel(rate_sel_i), .strobe(strobe)
  );

  for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
    ffm_axis_cmp u_cmp (
      .sample (axes_i[i*SAMPLE_W +: SAMPLE_W]),
      .ff_thr (cfg.ff_thr),
      .mot_thr(cfg.mot_thr),
      .below  (below[i]),
      .above  (above[i])
    );

    AST_THR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
      (cfg.ff_thr <= cfg.mot_thr) |-> !(below[i] && above[i]))
      else $error("axis both near and far"); // R1
  end

  assign ff_crit  = &below;
  assign mot_crit = |above;
  assign ff_clr   = !ff_en_i;
  assign mot_clr  = mot_latch_i && !mot_en_i;

  ffm_event_det u_ff (
    .clk(clk), .rst_n(rst_int_n), .strobe(strobe), .crit(ff_crit),
    .dly(cfg.ff_dly), .latch(ff_latch_i), .clr(ff_clr), .flag(ff_flag)
  );

  ffm_event_det u_mot (
    .clk(clk), .rst_n(rst_int_n), .strobe(strobe), .crit(mot_crit),
    .dly(cfg.mot_dly), .latch(mot_latch_i), .clr(mot_clr), .flag(mot_flag)
  );

  assign ff_flag_o  = ff_flag;
  assign mot_flag_o = mot_flag;
  assign irq_o      = ff_flag | (mot_flag & mot_en_i);

  AST_FF_GATED: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ff_en_i |=> !ff_flag_o) else $error("free-fall while disabled"); // R8
  AST_MOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mot_latch_i && !mot_en_i) |=> !mot_flag_o) else $error("motion latch not released"); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ff_flag_o && !mot_en_i) |-> !irq_o) else $error("irq without source"); // R5
  AST_FF_NEEDS_CRIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ff_flag_o) |-> $past(ff_crit)) else $error("free-fall rose without condition"); // R1
  AST_MOT_NEEDS_CRIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mot_flag_o) |-> $past(mot_crit)) else $error("motion rose without condition"); // R2
endmodule

// File: tb/tb_ffmot_irq_engine.sv
`timescale 1ns/1ps
module tb_ffmot_irq_engine;
  localparam int B = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [23:0] axes;
  logic [1:0]  rate_sel;
  logic cfg_wr;
  logic [7:0] ff_thr_in, mot_thr_in, ff_dly_in, mot_dly_in;
  logic ff_latch, mot_latch, ff_en, mot_en;
  logic irq, ff_flag, mot_flag;

  always #2 clk = ~clk;

  ffmot_irq_engine #(.NUM_AXES(3), .CLK_PER_TICK(B)) dut (
    .clk(clk), .rst_n(rst_n), .axes_i(axes), .rate_sel_i(rate_sel),
    .cfg_wr_i(cfg_wr), .ff_thr_i(ff_thr_in), .mot_thr_i(mot_thr_in),
    .ff_dly_i(ff_dly_in), .mot_dly_i(mot_dly_in),
    .ff_latch_i(ff_latch), .mot_latch_i(mot_latch),
    .ff_en_i(ff_en), .mot_en_i(mot_en),
    .irq_o(irq), .ff_flag_o(ff_flag), .mot_flag_o(mot_flag)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R9";
  bit done = 0;

  // behavioural reference
  int sync_cnt, k;
  int m_ff_thr, m_mot_thr, m_ff_dly, m_mot_dly;
  int m_ff_cnt, m_mot_cnt;
  bit m_ff, m_mot;

  function automatic int mag(input int s);
    return (s >= 128) ? s - 128 : 128 - s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt = 0; k = 0;
      m_ff_thr = 14; m_mot_thr = 85; m_ff_dly = 1; m_mot_dly = 1;
      m_ff_cnt = 0; m_mot_cnt = 0; m_ff = 0; m_mot = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      int ratio, c;
      bit stb, ffc, motc, q;
      c = rate_sel;
      ratio = 1 << (2 * (3 - c));
      stb = (k % B == B - 1) && (((k / B) % ratio) == ratio - 1);
      ffc = 1; motc = 0;
      for (int a = 0; a < 3; a++) begin
        int s;
        s = (axes >> (8 * a)) & 8'hFF;
        if (!(mag(s) < m_ff_thr)) ffc = 0;
        if (mag(s) > m_mot_thr) motc = 1;
      end
      if (!ff_en) begin
        m_ff_cnt = 0; m_ff = 0;
      end else if (stb) begin
        q = ffc && (m_ff_cnt >= m_ff_dly);
        if (!ffc) m_ff_cnt = 0; else if (!q) m_ff_cnt++;
        m_ff = ff_latch ? (m_ff | q) : q;
      end
      if (mot_latch && !mot_en) begin
        m_mot_cnt = 0; m_mot = 0;
      end else if (stb) begin
        q = motc && (m_mot_cnt >= m_mot_dly);
        if (!motc) m_mot_cnt = 0; else if (!q) m_mot_cnt++;
        m_mot = mot_latch ? (m_mot | q) : q;
      end
      if (cfg_wr) begin
        m_ff_thr = ff_thr_in; m_mot_thr = mot_thr_in;
        m_ff_dly = ff_dly_in; m_mot_dly = mot_dly_in;
      end
      k++;
    end
  end

  task automatic check(input string what, input logic act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", cur_req, what, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("ff_flag", ff_flag, m_ff);
      check("mot_flag", mot_flag, m_mot);
      check("irq", irq, m_ff | (m_mot & mot_en));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_axes(input int x, input int y, input int z);
    axes = {z[7:0], y[7:0], x[7:0]};
  endtask

  task automatic write_cfg(input int ft, input int mt, input int fd, input int md);
    @(negedge clk);
    ff_thr_in = ft[7:0]; mot_thr_in = mt[7:0];
    ff_dly_in = fd[7:0]; mot_dly_in = md[7:0];
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; set_axes(128, 128, 128); rate_sel = 2'b11; cfg_wr = 0;
    ff_thr_in = 0; mot_thr_in = 0; ff_dly_in = 0; mot_dly_in = 0;
    ff_latch = 0; mot_latch = 0; ff_en = 1; mot_en = 1;
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R9";
    check("reset irq", irq, 1'b0);
    check("reset ff", ff_flag, 1'b0);
    check("reset mot", mot_flag, 1'b0);
    // R9 default thresholds and delays
    wait_n(40);
    set_axes(142, 128, 128); wait_n(24);
    set_axes(141, 128, 128); wait_n(24);
    set_axes(213, 128, 128); wait_n(24);
    set_axes(214, 128, 128); wait_n(24);
    set_axes(128, 128, 128); wait_n(24);

    // R1 all-axes near zero g
    cur_req = "R1";
    write_cfg(20, 100, 0, 0);
    set_axes(147, 109, 147); wait_n(20);
    set_axes(147, 109, 108); wait_n(20);
    set_axes(148, 128, 128); wait_n(20);
    set_axes(128, 128, 110); wait_n(20);
    set_axes(128, 108, 128); wait_n(20);

    // R2 any-axis far from zero g
    cur_req = "R2";
    set_axes(128, 28, 128); wait_n(20);
    set_axes(128, 27, 128); wait_n(20);
    set_axes(128, 128, 255); wait_n(20);
    set_axes(228, 128, 128); wait_n(20);
    set_axes(229, 0, 128); wait_n(20);
    set_axes(128, 128, 128); wait_n(20);

    // R3 debounce counts and restarts
    cur_req = "R3";
    write_cfg(20, 100, 5, 3);
    for (int len = 1; len <= 7; len++) begin
      set_axes(240, 128, 128); wait_n(4 * len);
      set_axes(128, 128, 128); wait_n(4 * len);
    end
    write_cfg(20, 100, 0, 0);
    for (int len = 1; len <= 3; len++) begin
      set_axes(128, 240, 128); wait_n(4 * len + 1);
      set_axes(128, 128, 128); wait_n(6);
    end

    // R4 slower sample rates
    cur_req = "R4";
    write_cfg(20, 100, 2, 1);
    for (int r = 2; r >= 0; r--) begin
      rate_sel = r[1:0];
      for (int t = 0; t < 4; t++) begin
        set_axes(128, 128, 20); wait_n((1 << (2 * (3 - r))) * B * 3 + 5);
        set_axes(128, 128, 128); wait_n((1 << (2 * (3 - r))) * B * 3 + 7);
      end
    end
    rate_sel = 2'b11;

    // R5 motion gated by enable pin
    cur_req = "R5";
    write_cfg(20, 100, 0, 0);
    set_axes(250, 128, 128); wait_n(12);
    for (int t = 0; t < 6; t++) begin
      mot_en = ~mot_en; wait_n(3 + t);
    end
    mot_en = 1; wait_n(8);

    // R6 unlatched flags follow the condition
    cur_req = "R6";
    set_axes(128, 128, 128); wait_n(12);
    set_axes(250, 128, 128); wait_n(12);
    set_axes(130, 128, 128); wait_n(12);

    // R7 sticky motion
    cur_req = "R7";
    mot_latch = 1;
    set_axes(250, 128, 128); wait_n(12);
    set_axes(150, 128, 128); wait_n(30);
    mot_en = 0; wait_n(1);
    mot_en = 1; wait_n(20);
    set_axes(250, 128, 128); wait_n(8);
    set_axes(150, 128, 128); wait_n(8);
    mot_en = 0; set_axes(250, 128, 128); wait_n(20);
    mot_en = 1; wait_n(12);
    mot_latch = 0; set_axes(150, 128, 128); wait_n(12);

    // R8 sticky free-fall and its enable
    cur_req = "R8";
    ff_latch = 1;
    set_axes(128, 128, 128); wait_n(12);
    set_axes(150, 128, 128); wait_n(30);
    ff_en = 0; wait_n(1);
    ff_en = 1; wait_n(20);
    set_axes(128, 128, 128); ff_en = 0; wait_n(40);
    ff_latch = 0; wait_n(20);
    ff_en = 1; wait_n(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule